// File: doc/BRIEF.md
# Memory Cycle Clock Stretcher

This block sets the quarter-phase timing of a processor's machine cycles. Each clock of `clk_i` is one quarter phase. A cycle normally runs quarters 1, 2, 3 and 4, then begins again at 1. When stretch mode is on, some memory subcycles receive one extra copy of the final quarter. A stretched cycle runs 1, 2, 3, 4, 4, which makes it a quarter longer than a normal one. During that repeated quarter the block lowers a core clock-enable, so the rest of the core holds its state.

The stretch decision depends only on the subcycle type and the read-modify-write flag. Address subcycles are always stretched. The read-data subcycle of a read-modify-write is also stretched. Idle or default cycles, write-data subcycles and plain reads keep four quarters. The page-mode input has no effect on the decision. The controls are sampled in quarter 1 and held until the cycle ends. A change made later in the cycle applies to the next cycle.

Top module: `qstretch_timer`

## Requirements
- R1: A synchronous reset, whether applied in the middle of a cycle or during the repeated quarter, sets the outputs in the next quarter to: `phase_o` = 1, `stretch_o` = 0, `end_o` = 0 and `core_ce_o` = 1. No stretch stays pending, so the cycle after reset is decided only by its own controls.
- R2: `phase_o` takes the values 1, 2, 3, 4 in that order, advancing by one on each clock and never leaving the range 1 to 4.
- R3: With `stretch_en_i` = 1 and `sub_kind_i` = 1 (address), the cycle runs five quarters (1,2,3,4,4), and `stretch_o` = 1 only in the fifth quarter.
- R4: With `stretch_en_i` = 1 and `sub_kind_i` = 2 (read data), the cycle is stretched when `rmw_i` = 1 and runs four quarters when `rmw_i` = 0.
- R5: With `sub_kind_i` = 0 (idle/default) or 3 (write data), the cycle runs four quarters whatever the other controls are.
- R6: `page_mode_i` has no effect on cycle length or on any output. A non-page-mode read-modify-write read-data subcycle is still stretched.
- R7: With `stretch_en_i` = 0, every cycle runs exactly four quarters.
- R8: The controls are sampled in quarter 1. Changes during quarters 2 to 4 do not alter the length of the current cycle.
- R9: `core_ce_o` is 0 exactly during the repeated quarter and 1 in every other quarter.
- R10: `end_o` pulses for exactly one quarter per cycle, on its final quarter, and the next quarter is quarter 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Quarter-phase clock |
| rst_i | input | 1 | Synchronous reset, active high |
| stretch_en_i | input | 1 | Stretch mode enable |
| page_mode_i | input | 1 | Page-mode indication; no effect on the stretch decision |
| sub_kind_i | input | 2 | Subcycle type: 0 idle/default, 1 address, 2 read data, 3 write data |
| rmw_i | input | 1 | Current sequence is a read-modify-write |
| phase_o | output | 3 | Current quarter number, 1 to 4 |
| stretch_o | output | 1 | High during the repeated quarter |
| end_o | output | 1 | High on the final quarter of each cycle |
| core_ce_o | output | 1 | Core clock-enable, low during the repeated quarter |

## Verification
The situations hardest to reach are these: a control that changes after quarter 1 but must not affect the current cycle, and a reset that arrives while the repeated quarter is active. The bench covers every combination of enable, type, read-modify-write flag and page mode. In each cycle it inverts every control at quarter 2, so any late sampling would change the cycle length. A separate sequence stops a stretched address cycle in its fifth quarter with reset and then checks that the next cycle is a plain four-quarter one.

// File: rtl/qstretch_pkg.sv
package qstretch_pkg;

  typedef enum logic [1:0] {
    SUB_IDLE  = 2'd0,
    SUB_ADDR  = 2'd1,
    SUB_RDATA = 2'd2,
    SUB_WDATA = 2'd3
  } sub_kind_e;

  // Stretch rule: address subcycles, plus read data inside read-modify-write.
  function automatic logic wants_extra(input logic en, input sub_kind_e kind,
                                       input logic rmw);
    logic typed;
    typed = (kind == SUB_ADDR) || ((kind == SUB_RDATA) && rmw);
    return en && typed;
  endfunction

  // Quarters in one cycle for a given stretch decision.
  function automatic int unsigned cycle_quarters(input int unsigned quarters,
                                                 input int unsigned extra,
                                                 input logic stretched);
    return stretched ? quarters + extra : quarters;
  endfunction

endpackage

// File: rtl/qs_policy.sv
module qs_policy
  import qstretch_pkg::*;
(
  input  logic      en_i,
  input  sub_kind_e kind_i,
  input  logic      rmw_i,
  output logic      extra_o
);
  always_comb extra_o = wants_extra(en_i, kind_i, rmw_i);
endmodule

// File: rtl/qs_decision_hold.sv
module qs_decision_hold (
  input  logic clk_i,
  input  logic rst_i,
  input  logic capture_i,
  input  logic extra_i,
  output logic held_o
);
  logic held_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)          held_q <= 1'b0;
    else if (capture_i) held_q <= extra_i;
  end

  assign held_o = held_q;

  // R8: the decision stays fixed outside quarter 1
  assert_hold_stable_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!capture_i && !$past(capture_i) && !$past(rst_i)) |-> $stable(held_q));
endmodule

// File: rtl/qs_phase_seq.sv
module qs_phase_seq #(
  parameter int unsigned QUARTERS = 4,
  parameter int unsigned EXTRA    = 1,
  localparam int unsigned PH_W    = $clog2(QUARTERS + 1),
  localparam int unsigned REP_W   = (EXTRA > 0) ? $clog2(EXTRA + 1) : 1
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            stretch_req_i,
  output logic [PH_W-1:0] phase_o,
  output logic            first_o,
  output logic            in_extra_o,
  output logic            last_o
);
  localparam logic [PH_W-1:0]  PH_FIRST = PH_W'(1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(QUARTERS);
  localparam logic [REP_W-1:0] REP_MAX  = REP_W'(EXTRA);

  logic [PH_W-1:0]  phase_q;
  logic [REP_W-1:0] rep_q;
  logic [REP_W-1:0] rep_target;
  logic             at_top;
  logic             more_reps;

  always_comb begin
    rep_target = stretch_req_i ? REP_MAX : '0;
    at_top     = (phase_q == PH_LAST);
    more_reps  = at_top && (rep_q < rep_target);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= PH_FIRST;
      rep_q   <= '0;
    end else if (!at_top) begin
      phase_q <= phase_q + PH_W'(1);
    end else if (more_reps) begin
      rep_q <= rep_q + REP_W'(1);
    end else begin
      phase_q <= PH_FIRST;
      rep_q   <= '0;
    end
  end

  assign phase_o    = phase_q;
  assign first_o    = (phase_q == PH_FIRST) && (rep_q == '0);
  assign in_extra_o = (rep_q != '0);
  assign last_o     = at_top && !more_reps;

  assert_phase_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_o >= PH_FIRST) && (phase_o <= PH_LAST));

  assert_phase_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_o < PH_LAST) |=> (phase_o == $past(phase_o) + PH_W'(1)));

  assert_wrap_after_end_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    last_o |=> (phase_o == PH_FIRST) && !in_extra_o);
endmodule

// File: rtl/qstretch_timer.sv
module qstretch_timer
  import qstretch_pkg::*;
#(
  parameter int unsigned QUARTERS = 4,
  parameter int unsigned EXTRA    = 1,
  localparam int unsigned PH_W    = $clog2(QUARTERS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            stretch_en_i,
  input  logic            page_mode_i,
  input  logic [1:0]      sub_kind_i,
  input  logic            rmw_i,
  output logic [PH_W-1:0] phase_o,
  output logic            stretch_o,
  output logic            end_o,
  output logic            core_ce_o
);
  sub_kind_e kind_w;
  logic      extra_now_w;
  logic      extra_held_w;
  logic      first_w;
  logic      in_extra_w;
  logic      last_w;

  assign kind_w = sub_kind_e'(sub_kind_i);

  qs_policy u_policy (
    .en_i    (stretch_en_i),
    .kind_i  (kind_w),
    .rmw_i   (rmw_i),
    .extra_o (extra_now_w)
  );

  qs_decision_hold u_hold (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .capture_i (first_w),
    .extra_i   (extra_now_w),
    .held_o    (extra_held_w)
  );

  qs_phase_seq #(.QUARTERS(QUARTERS), .EXTRA(EXTRA)) u_seq (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .stretch_req_i (extra_held_w),
    .phase_o       (phase_o),
    .first_o       (first_w),
    .in_extra_o    (in_extra_w),
    .last_o        (last_w)
  );

  assign stretch_o = in_extra_w;
  assign end_o     = last_w;
  assign core_ce_o = !in_extra_w;

  assert_stretch_after_top_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    stretch_o |-> (phase_o == PH_W'(QUARTERS)) && ($past(phase_o) == PH_W'(QUARTERS)));

  assert_addr_held_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (first_w && stretch_en_i && (kind_w == SUB_ADDR)) |=> extra_held_w);

  assert_rmw_read_held_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (first_w && stretch_en_i && (kind_w == SUB_RDATA) && rmw_i) |=> extra_held_w);

  assert_plain_kinds_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (first_w && ((kind_w == SUB_IDLE) || (kind_w == SUB_WDATA))) |=> !extra_held_w);

  assert_nonpage_rmw_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (first_w && stretch_en_i && (kind_w == SUB_RDATA) && rmw_i && !page_mode_i)
      |=> extra_held_w);

  assert_disabled_plain_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (first_w && !stretch_en_i) |=> !extra_held_w);

  assert_ce_gap_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !core_ce_o |-> $past(core_ce_o));
endmodule

// File: tb/tb_qstretch_timer.sv
module tb_qstretch_timer;
  logic       clk = 1'b0;
  logic       rst;
  logic       en, pg, rmw;
  logic [1:0] kind;
  logic [2:0] phase;
  logic       stretch, endc, ce;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  qstretch_timer dut (
    .clk_i(clk), .rst_i(rst), .stretch_en_i(en), .page_mode_i(pg),
    .sub_kind_i(kind), .rmw_i(rmw), .phase_o(phase), .stretch_o(stretch),
    .end_o(endc), .core_ce_o(ce)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_len(input bit e, input int k, input bit r);
    return 4 + ((e && (k == 1 || (k == 2 && r))) ? 1 : 0);
  endfunction

  // Called at a negedge while quarter 1 is showing.
  task automatic run_cycle(input bit e, input int k, input bit r, input bit p,
                           input string req);
    int len = exp_len(e, k, r);
    en = e; kind = 2'(k); rmw = r; pg = p;
    for (int i = 0; i < len; i++) begin
      int ph = (i < 4) ? i + 1 : 4;
      check(phase == 3'(ph), {req, " R2 phase"}, phase, ph);
      check(stretch == (i == 4), {req, " R3 stretch"}, stretch, i == 4);
      check(ce == (i != 4), {req, " R9 core_ce"}, ce, i != 4);
      check(endc == (i == len - 1), {req, " R10 end"}, endc, i == len - 1);
      if (i == 1) begin
        // R8: invert all controls after quarter 1
        en = ~e; kind = 2'(3 - k); rmw = ~r; pg = ~p;
      end
      @(negedge clk);
    end
    check(phase == 3'd1, {req, " R10 wrap"}, phase, 1);
  endtask

  initial begin
    rst = 1'b1; en = 0; pg = 0; rmw = 0; kind = 0;
    repeat (3) @(negedge clk);
    check(phase == 3'd1, "R1 reset phase", phase, 1);
    check(!stretch, "R1 reset stretch", stretch, 0);
    check(ce, "R1 reset ce", ce, 1);
    check(!endc, "R1 reset end", endc, 0);
    rst = 1'b0;

    // Full sweep over R3 R4 R5 R6 R7 R8
    for (int k = 0; k < 4; k++)
      for (int e = 0; e < 2; e++)
        for (int r = 0; r < 2; r++)
          for (int p = 0; p < 2; p++)
            run_cycle(e[0], k, r[0], p[0], "sweep R3 R4 R5 R6 R7");

    // Two non-page reads, stretched: address, read, address, read
    run_cycle(1, 1, 0, 0, "reads R3");
    run_cycle(1, 2, 0, 0, "reads R4");
    run_cycle(1, 1, 0, 0, "reads R3");
    run_cycle(1, 2, 0, 0, "reads R4");
    // Page-mode read-modify-write: address, read, write
    run_cycle(1, 1, 1, 1, "rmw R3");
    run_cycle(1, 2, 1, 1, "rmw R4 R6");
    run_cycle(1, 3, 1, 1, "rmw R5");
    // Non-page read-modify-write read data still stretched
    run_cycle(1, 2, 1, 0, "nonpage rmw R6");
    // Disabled: address stays at four quarters
    run_cycle(0, 1, 1, 1, "disabled R7");

    // R1: reset during the repeated quarter
    en = 1; kind = 2'd1; rmw = 0; pg = 0;
    repeat (4) @(negedge clk);
    check(stretch, "R1 pre-reset stretch", stretch, 1);
    rst = 1'b1;
    @(negedge clk);
    check(phase == 3'd1, "R1 mid reset phase", phase, 1);
    check(!stretch, "R1 mid reset stretch", stretch, 0);
    check(ce, "R1 mid reset ce", ce, 1);
    check(!endc, "R1 mid reset end", endc, 0);
    rst = 1'b0;
    run_cycle(1, 0, 0, 0, "after reset R1 R5");

    // R1: reset in quarter 3, then a stretched cycle proceeds
    en = 1; kind = 2'd1;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(phase == 3'd1, "R1 reset q3 phase", phase, 1);
    rst = 1'b0;
    run_cycle(1, 1, 0, 1, "after reset R1 R3");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule